// File: doc/BRIEF.md
# Addressed Four-Port Serial Control Hub

The hub sits on a shared serial control line that a single master drives. The master sends one command at a time as a bit-strobed frame. Every hub on the line decodes the frame. Only the hub whose strap address matches the frame acts on it. That hub runs the command as a two-wire transfer on one of its four I2C-style ports. It then sends a single-cycle response back to the master. The response carries an error flag and, for a read, the byte it read back.

A frame has 31 bits and is shifted most significant bit first. It opens with a start bit of value 1. The fields that follow are a 4-bit hub address, a 2-bit port number and a direction bit (0 = write, 1 = read). After those come a 7-bit device address, an 8-bit register index and an 8-bit data byte. The hub ignores strobes that carry 0 while it waits for a frame. A write puts out, in order, a start condition, the device address with direction bit 0, the register index, the data byte and a stop condition. A read puts out the device address and the register index. It then sends a repeated start and the device address with direction bit 1, clocks in one byte, answers it with a not-acknowledge and sends a stop.

Each port has one clock output and one open-drain data line. The data line is split into a drive output (0 pulls the line low, 1 releases it) and a sensed input. Ports flagged in a parameter mask serve slow devices and run their clock eight times slower than the others.

Top module: `ctl_hub`

## Requirements
- R1: A frame is recognised only after a strobed 1 (start bit) and is taken MSB first as hub[29:26], port[25:24], rw[23], device[22:16], register[15:8], data[7:0] of the 30 bits after the start bit; strobes carrying 0 before the start bit are ignored.
- R2: A frame whose hub field differs from `hub_id` causes no response pulse and leaves every clock and data output high.
- R3: During a transfer only the port named in the frame may drive its clock or data output low; the other three stay high.
- R4: A write sends start, {device,0}, register, data, each followed by a released acknowledge slot, then stop; it responds with `rsp_err`=0 and `rsp_data`=0.
- R5: A read sends start, {device,0}, register, repeated start, {device,1}, releases the line for eight data bits, drives not-acknowledge (high) in the ninth slot, then stop; `rsp_data` carries the byte sampled MSB first.
- R6: A high level in any acknowledge slot of a byte the hub sent ends the transfer with a stop condition and a response with `rsp_err`=1 and `rsp_data`=0.
- R7: Every clock high time lasts 2×DIV_SLOW cycles on ports whose bit in SLOW_MASK is set (default port 3, DIV_SLOW=8) and 2×DIV_FAST cycles on the others (DIV_FAST=1).
- R8: A frame that completes while a transfer is running is discarded and produces no transfer and no response.
- R9: After reset all clock and data outputs are high and `rsp_valid` is 0; every transfer ends with exactly one single-cycle `rsp_valid` pulse after its stop condition.
- R10: While a port clock is high its data line changes only for start, repeated start and stop conditions: a write or an aborted transfer shows 2 such changes, a completed read 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hub_id | input | 4 | Strap address of this hub |
| ctl_stb | input | 1 | One-cycle strobe marking a valid frame bit |
| ctl_dat | input | 1 | Frame bit, sampled when `ctl_stb` is high |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_err | output | 1 | Missing acknowledge seen during the transfer |
| rsp_data | output | 8 | Byte read back, zero for writes and errors |
| scl_o | output | 4 | Clock output per port |
| sda_o | output | 4 | Data drive per port, 0 pulls low, 1 releases |
| sda_i | input | 4 | Sensed data line level per port |

## Verification
A bad phase or bit counter shows up on the active port's lines within one bit time. The clock high run takes the wrong length, or the data line moves while the clock is high, and a device model then drops the byte or the acknowledge. A wrong byte index or a bad direction decision surfaces only at the end of the transfer: the response comes back with the wrong data or error flag, or a register read later holds the wrong value. A bad address compare or a bad busy check shows as a response pulse or a low line where none should appear, a few hundred cycles after the frame.

// File: rtl/ctl_hub.sv
module ctl_hub #(
  parameter int         DIV_FAST  = 1,
  parameter int         DIV_SLOW  = 8,
  parameter logic [3:0] SLOW_MASK = 4'b1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] hub_id,
  input  logic       ctl_stb,
  input  logic       ctl_dat,
  output logic       rsp_valid,
  output logic       rsp_err,
  output logic [7:0] rsp_data,
  output logic [3:0] scl_o,
  output logic [3:0] sda_o,
  input  logic [3:0] sda_i
);

  localparam int DW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_RSTART, S_STOP} st_t;

  st_t         st;
  logic [1:0]  ph;
  logic [DW-1:0] divc;
  logic [3:0]  bcnt;
  logic [1:0]  bidx;
  logic [1:0]  sel;
  logic        rw;
  logic [6:0]  dev;
  logic [7:0]  regad;
  logic [7:0]  wdat;
  logic [7:0]  rd;
  logic        ackb;
  logic        err;

  logic        rx_on;
  logic [4:0]  rx_cnt;
  logic [28:0] rx_sh;

  wire        frm_done = ctl_stb && rx_on && (rx_cnt == 5'd29);
  wire [29:0] frm      = {rx_sh, ctl_dat};
  wire        start_ok = frm_done && (frm[29:26] == hub_id) && (st == S_IDLE);

  wire [DW-1:0] lim  = SLOW_MASK[sel] ? DW'(DIV_SLOW - 1) : DW'(DIV_FAST - 1);
  wire          tick = (divc == lim);
  wire          sda_bus = sda_i[sel];

  logic [7:0] txb;
  always_comb begin
    case (bidx)
      2'd0:    txb = {dev, 1'b0};
      2'd1:    txb = regad;
      2'd2:    txb = rw ? {dev, 1'b1} : wdat;
      default: txb = 8'hFF;
    endcase
  end

  wire bit_out = (bcnt == 4'd8) ? 1'b1 : txb[3'd7 - bcnt[2:0]];

  logic scl_l, sda_l;
  always_comb begin
    case (st)
      S_START:  begin scl_l = (ph < 2'd2);                   sda_l = (ph == 2'd0); end
      S_BITS:   begin scl_l = (ph == 2'd1) || (ph == 2'd2);  sda_l = bit_out;      end
      S_RSTART: begin scl_l = (ph == 2'd1) || (ph == 2'd2);  sda_l = (ph < 2'd2);  end
      S_STOP:   begin scl_l = (ph != 2'd0);                  sda_l = (ph >= 2'd2); end
      default:  begin scl_l = 1'b1;                          sda_l = 1'b1;         end
    endcase
  end

  always_comb begin
    for (int p = 0; p < 4; p++) begin
      scl_o[p] = (st != S_IDLE && sel == 2'(p)) ? scl_l : 1'b1;
      sda_o[p] = (st != S_IDLE && sel == 2'(p)) ? sda_l : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_on <= 1'b0;
      rx_cnt <= '0;
      rx_sh <= '0;
    end else if (ctl_stb) begin
      if (!rx_on) begin
        if (ctl_dat) begin
          rx_on  <= 1'b1;
          rx_cnt <= '0;
        end
      end else begin
        rx_sh <= {rx_sh[27:0], ctl_dat};
        if (rx_cnt == 5'd29) rx_on <= 1'b0;
        else rx_cnt <= rx_cnt + 5'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= '0;
      divc <= '0;
      bcnt <= '0;
      bidx <= '0;
      sel <= '0;
      rw <= 1'b0;
      dev <= '0;
      regad <= '0;
      wdat <= '0;
      rd <= '0;
      ackb <= 1'b0;
      err <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (start_ok) begin
          sel   <= frm[25:24];
          rw    <= frm[23];
          dev   <= frm[22:16];
          regad <= frm[15:8];
          wdat  <= frm[7:0];
          st    <= S_START;
          ph    <= '0;
          divc  <= '0;
          bcnt  <= '0;
          bidx  <= '0;
          err   <= 1'b0;
          rd    <= '0;
        end
      end else if (!tick) begin
        divc <= divc + DW'(1);
      end else begin
        divc <= '0;
        ph   <= ph + 2'd1;
        if (st == S_BITS && ph == 2'd2) begin
          if (bcnt == 4'd8) ackb <= sda_bus;
          else if (bidx == 2'd3) rd <= {rd[6:0], sda_bus};
        end
        if (ph == 2'd3) begin
          case (st)
            S_START, S_RSTART: begin
              st   <= S_BITS;
              bcnt <= '0;
            end
            S_BITS: begin
              if (bcnt != 4'd8) begin
                bcnt <= bcnt + 4'd1;
              end else begin
                bcnt <= '0;
                if (ackb && bidx != 2'd3) begin
                  err <= 1'b1;
                  st  <= S_STOP;
                end else if ((!rw && bidx == 2'd2) || (rw && bidx == 2'd3)) begin
                  st <= S_STOP;
                end else if (rw && bidx == 2'd1) begin
                  st   <= S_RSTART;
                  bidx <= 2'd2;
                end else begin
                  bidx <= bidx + 2'd1;
                end
              end
            end
            S_STOP: begin
              st        <= S_IDLE;
              rsp_valid <= 1'b1;
              rsp_err   <= err;
              rsp_data  <= (rw && !err) ? rd : 8'h00;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R9

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~(scl_o & sda_o)) <= 1);  // R3

  AST_HUB_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm[29:26] != hub_id && st == S_IDLE) |=> (st == S_IDLE && scl_o == 4'hF));  // R2

  AST_ERR_NODATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == 8'h00));  // R6

  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BITS && $past(st) == S_BITS && scl_l && $past(scl_l)) |-> $stable(sda_l));  // R10

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && st != S_IDLE && st != S_STOP) |=> (st != S_IDLE && $stable(sel)));  // R8

endmodule

// File: tb/ctl_hub_bench.sv
module ctl_hub_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hub_id = 4'h9;
  logic       ctl_stb = 1'b0;
  logic       ctl_dat = 1'b0;
  logic       rsp_valid, rsp_err;
  logic [7:0] rsp_data;
  logic [3:0] scl_o, sda_o, sda_i;

  always #10 clk = ~clk;

  ctl_hub u_ctl_hub (
    .clk(clk), .rst_n(rst_n), .hub_id(hub_id), .ctl_stb(ctl_stb), .ctl_dat(ctl_dat),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
  );

  int total = 0;
  int bad = 0;

  localparam logic [6:0] DEV_A = 7'h2A;

  logic [1:0] dev_port = 2'd0;
  logic       pull = 1'b1;

  always_comb begin
    for (int p = 0; p < 4; p++)
      sda_i[p] = sda_o[p] & ((2'(p) == dev_port) ? pull : 1'b1);
  end

  logic [7:0] mem [16];
  logic       active = 1'b0, matched = 1'b0, rmode = 1'b0;
  logic [3:0] bitc = '0;
  logic [1:0] byte_n = '0;
  logic [7:0] shreg = '0, txd = '0;
  logic [3:0] ptr = '0;
  logic       p_scl = 1'b1, p_sda = 1'b1;

  int ev_cnt = 0, hr = 0, falls = 0, hr2 = 0, other_low = 0, any_low = 0, rsp_cnt = 0;

  always @(negedge clk) begin
    logic s_scl, s_sda;
    s_scl = scl_o[dev_port];
    s_sda = sda_i[dev_port];
    if (s_scl && p_scl && s_sda != p_sda) ev_cnt++;
    if (s_scl) hr++;
    else begin
      if (p_scl) begin
        falls++;
        if (falls == 2) hr2 = hr;
      end
      hr = 0;
    end
    for (int p = 0; p < 4; p++)
      if (2'(p) != dev_port && (!scl_o[p] || !sda_o[p])) other_low++;
    if (scl_o != 4'hF || sda_o != 4'hF) any_low++;
    if (rsp_valid) rsp_cnt++;

    if (s_scl && p_scl && p_sda && !s_sda) begin
      active = 1'b1; bitc = 0; byte_n = 0; rmode = 1'b0; pull = 1'b1;
    end else if (s_scl && p_scl && !p_sda && s_sda) begin
      active = 1'b0; pull = 1'b1;
    end else if (active && s_scl && !p_scl) begin
      if (bitc < 8) shreg = {shreg[6:0], s_sda};
      bitc++;
    end else if (active && !s_scl && p_scl) begin
      if (bitc == 8) begin
        if (byte_n == 0) begin
          matched = (shreg[7:1] == DEV_A);
          rmode = shreg[0];
          pull = !matched;
        end else if (rmode) begin
          pull = 1'b1;
        end else begin
          if (byte_n == 1) ptr = shreg[3:0];
          else if (matched) mem[ptr] = shreg;
          pull = !matched;
        end
        byte_n++;
      end else if (bitc == 9) begin
        bitc = 0;
        if (rmode && matched && byte_n == 1) begin
          txd = mem[ptr];
          pull = txd[7];
        end else pull = 1'b1;
      end else if (rmode && matched && byte_n == 1 && bitc >= 1) begin
        pull = txd[3'd7 - bitc[2:0]];
      end
    end
    p_scl = s_scl;
    p_sda = s_sda;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); #1;
    ev_cnt = 0; hr = 0; falls = 0; hr2 = 0; other_low = 0; any_low = 0; rsp_cnt = 0;
  endtask

  task automatic send_frame(input logic [3:0] hub, input logic [1:0] port, input logic rw,
                            input logic [6:0] dev, input logic [7:0] rg, input logic [7:0] dat);
    logic [30:0] f;
    f = {1'b1, hub, port, rw, dev, rg, dat};
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1; ctl_stb = 1'b1; ctl_dat = 1'b0;
    end
    for (int i = 30; i >= 0; i--) begin
      @(negedge clk); #1; ctl_stb = 1'b1; ctl_dat = f[i];
    end
    @(negedge clk); #1; ctl_stb = 1'b0; ctl_dat = 1'b0;
  endtask

  task automatic wait_rsp(output bit got, output logic e, output logic [7:0] d);
    got = 1'b0; e = 1'b0; d = '0;
    for (int i = 0; i < 6000 && !got; i++) begin
      @(negedge clk);
      if (rsp_valid) begin got = 1'b1; e = rsp_err; d = rsp_data; end
    end
    if (got) begin
      @(negedge clk);
      check(!rsp_valid, "R9 pulse width", 32'(rsp_valid), 0);
    end else check(1'b0, "R9 no response", 0, 1);
  endtask

  localparam int NV = 8;
  localparam logic [36:0] VEC [NV] = '{
    {2'd0, 1'b0, 7'h2A, 8'h03, 8'hA5, 1'b0, 8'h00, 2'd2},
    {2'd0, 1'b1, 7'h2A, 8'h03, 8'h00, 1'b0, 8'hA5, 2'd3},
    {2'd2, 1'b0, 7'h2A, 8'h05, 8'h3C, 1'b0, 8'h00, 2'd2},
    {2'd2, 1'b1, 7'h2A, 8'h05, 8'hFF, 1'b0, 8'h3C, 2'd3},
    {2'd3, 1'b0, 7'h2A, 8'h01, 8'h81, 1'b0, 8'h00, 2'd2},
    {2'd3, 1'b1, 7'h2A, 8'h01, 8'h00, 1'b0, 8'h81, 2'd3},
    {2'd1, 1'b0, 7'h11, 8'h02, 8'h55, 1'b1, 8'h00, 2'd2},
    {2'd1, 1'b1, 7'h11, 8'h02, 8'h00, 1'b1, 8'h00, 2'd2}
  };

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got;
    logic e;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(scl_o == 4'hF, "R9 reset scl", 32'(scl_o), 'hF);
    check(sda_o == 4'hF, "R9 reset sda", 32'(sda_o), 'hF);
    check(!rsp_valid, "R9 reset rsp_valid", 32'(rsp_valid), 0);

    for (int v = 0; v < NV; v++) begin
      logic [36:0] t;
      t = VEC[v];
      dev_port = t[36:35];
      clear_mon();
      send_frame(hub_id, t[36:35], t[34], t[33:27], t[26:19], t[18:11]);
      wait_rsp(got, e, d);
      repeat (3) @(negedge clk);
      check(e == t[10], "R6 error flag (R1 fields)", 32'(e), 32'(t[10]));
      check(d == t[9:2], t[34] ? "R5 read data" : "R4 write response data", 32'(d), 32'(t[9:2]));
      check(ev_cnt == int'(t[1:0]), "R10 data changes with clock high", ev_cnt, 32'(t[1:0]));
      check(other_low == 0, "R3 other ports idle", other_low, 0);
      check(rsp_cnt == 1, "R9 one response per transfer", rsp_cnt, 1);
      check(hr2 == ((t[36:35] == 2'd3) ? 16 : 2), "R7 clock high time", hr2,
            (t[36:35] == 2'd3) ? 16 : 2);
      check(scl_o == 4'hF && sda_o == 4'hF, "R6 lines released after stop", 32'({scl_o, sda_o}), 'hFF);
    end

    dev_port = 2'd0;
    clear_mon();
    send_frame(hub_id ^ 4'h1, 2'd0, 1'b0, DEV_A, 8'h03, 8'h77);
    repeat (400) @(negedge clk);
    check(rsp_cnt == 0, "R2 no response on hub mismatch", rsp_cnt, 0);
    check(any_low == 0, "R2 lines stay high on hub mismatch", any_low, 0);

    dev_port = 2'd3;
    clear_mon();
    send_frame(hub_id, 2'd3, 1'b0, DEV_A, 8'h07, 8'h11);
    send_frame(hub_id, 2'd3, 1'b0, DEV_A, 8'h07, 8'h22);
    wait_rsp(got, e, d);
    check(!e, "R8 first transfer completes", 32'(e), 0);
    repeat (1500) @(negedge clk);
    check(rsp_cnt == 1, "R8 busy frame discarded", rsp_cnt, 1);
    clear_mon();
    send_frame(hub_id, 2'd3, 1'b1, DEV_A, 8'h07, 8'h00);
    wait_rsp(got, e, d);
    check(d == 8'h11, "R8 register holds first value", 32'(d), 'h11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule